// File: doc/BRIEF.md
# Frame-Counting Receive FIFO

This block is the storage stage behind an HDLC receiver. The receiver hands it decoded bytes one at a time. It marks the last byte of each frame with an end-of-frame strobe. That last byte is the status byte placed after the CRC bytes. The bytes go into a circular byte store. Two byte pointers track the store: a write pointer that moves only when a byte is really stored, and a read pointer that moves on host reads. A second pair of counters sits alongside the byte pointers and counts whole frames. The frame write counter steps when a frame's closing byte is stored. The frame read counter steps when the host reads that closing byte. The frame counters are 5 bits wide, so the number of stored frames is their difference modulo 32. The number of stored bytes is the difference of the byte pointers.

The host sees only complete frames. Reads are honoured only while at least one whole frame is stored. Each byte comes out with a flag that marks the end of its frame. The FIFO reports full when either of two limits is reached, whichever comes first. The first limit is the number of stored frames reaching FRAME_LIMIT, however short the frames are. The second is the stored bytes reaching DEPTH. A byte that arrives while full is dropped and a sticky overflow flag is set. The frame it belongs to is removed by winding the byte write pointer back to where that frame began. Later bytes of that frame are ignored up to and including its end-of-frame byte.

The write side is a three-state machine:
- WR_IDLE: between frames.
- WR_FILL: a frame is partly stored.
- WR_DROP: the rest of a rejected frame is being discarded.

Its transitions are:
- IDLE->FILL: a byte is accepted without end-of-frame.
- FILL->IDLE and IDLE->IDLE: a closing byte is accepted (frame commit).
- IDLE/FILL->DROP: a byte without end-of-frame arrives while full.
- IDLE/FILL->IDLE: a closing byte arrives while full (rejected, nothing left to drop).
- DROP->IDLE: any end-of-frame byte arrives.

Top module: `frf_rx_fifo`

## Requirements
- R1: After reset, frames_stored and bytes_stored are 0, and full, overflow and rd_last are 0.
- R2: Each accepted byte raises bytes_stored by one on the next clock edge. The host reads bytes back in the order they were written.
- R3: While wr_valid is low, wr_data and wr_eof have no effect: bytes_stored and frames_stored do not change.
- R4: A byte written with wr_eof=1 closes its frame, and frames_stored rises by one on the next edge. When that byte is read, rd_last is 1. rd_last is 0 for every other byte.
- R5: rd_en is ignored while frames_stored is 0. The bytes of a partly stored frame cannot be read.
- R6: A read of a frame's closing byte (rd_last=1) lowers frames_stored by one. Every read lowers bytes_stored by one.
- R7: full is 1 whenever frames_stored equals FRAME_LIMIT (default 15), even when every frame is one byte long.
- R8: full is 1 whenever bytes_stored equals DEPTH (default 512), even inside an unfinished frame.
- R9: A byte written while full is not stored, and overflow becomes 1 and stays 1 until reset. bytes_stored falls back to its value at the start of the rejected frame. All further bytes are ignored up to and including the next wr_eof byte.
- R10: Once full has cleared, the first frame that starts after a rejected frame has closed is stored normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | A decoded byte is offered this cycle |
| wr_data | input | 8 | Decoded byte |
| wr_eof | input | 1 | Offered byte is the last (status) byte of its frame |
| rd_en | input | 1 | Host takes the byte on rd_data this cycle |
| rd_data | output | 8 | Byte at the read pointer |
| rd_last | output | 1 | rd_data is the last byte of its frame |
| frames_stored | output | 5 | Complete frames held |
| bytes_stored | output | $clog2(DEPTH)+1 | Bytes held, including a partly stored frame |
| full | output | 1 | Frame limit or byte capacity reached |
| overflow | output | 1 | Sticky: a byte was rejected since reset |

## Verification
The assertions assume two things about the inputs. The receiver ends every frame with a byte that carries wr_eof. The host does not care about rd_data while no whole frame is stored. The check that idle reads change nothing further assumes that no write is offered in the same cycle, because a rejected write may legally shrink the byte count then. The stimulus offers at most one byte per cycle and drives reads and writes in separate cycles. Every frame it sends is closed by an end-of-frame byte, and that includes the oversized frame that is rejected part-way through.

// File: rtl/frf_pkg.sv
package frf_pkg;
    localparam int FCNT_W = 5;

    typedef enum logic [1:0] {
        WR_IDLE,
        WR_FILL,
        WR_DROP
    } wr_state_e;

    typedef struct packed {
        logic       eof;
        logic [7:0] data;
    } fifo_word_t;
endpackage

// File: rtl/frf_store.sv
module frf_store #(
    parameter int DEPTH = 512
) (
    input  logic                      clk,
    input  logic                      we,
    input  logic [$clog2(DEPTH)-1:0]  waddr,
    input  frf_pkg::fifo_word_t       wword,
    input  logic [$clog2(DEPTH)-1:0]  raddr,
    output frf_pkg::fifo_word_t       rword
);
    frf_pkg::fifo_word_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wword;
        end
    end

    assign rword = mem[raddr];
endmodule

// File: rtl/frf_wr_ctrl.sv
module frf_wr_ctrl #(
    parameter int DEPTH = 512
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_valid,
    input  logic                             wr_eof,
    input  logic                             full,
    output logic                             mem_we,
    output logic [$clog2(DEPTH):0]           z1,
    output logic [frf_pkg::FCNT_W-1:0]       f1,
    output logic                             overflow
);
    import frf_pkg::*;

    localparam int PW = $clog2(DEPTH) + 1;
    localparam logic [PW-1:0]     PONE = PW'(1);
    localparam logic [FCNT_W-1:0] FONE = FCNT_W'(1);

    wr_state_e         state_q, state_d;
    logic [PW-1:0]     z1_q, zstart_q;
    logic [FCNT_W-1:0] f1_q;
    logic              ovf_q;
    logic              accept, commit, reject;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= WR_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state and strobes
    always_comb begin
        state_d = state_q;
        accept  = 1'b0;
        commit  = 1'b0;
        reject  = 1'b0;
        unique case (state_q)
            WR_IDLE, WR_FILL: begin
                if (wr_valid) begin
                    if (full) begin
                        reject  = 1'b1;
                        state_d = wr_eof ? WR_IDLE : WR_DROP;
                    end else begin
                        accept  = 1'b1;
                        commit  = wr_eof;
                        state_d = wr_eof ? WR_IDLE : WR_FILL;
                    end
                end
            end
            WR_DROP: begin
                if (wr_valid && wr_eof) begin
                    state_d = WR_IDLE;
                end
            end
            default: state_d = WR_IDLE;
        endcase
    end

    // pointers, frame counter, sticky flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            z1_q     <= '0;
            zstart_q <= '0;
            f1_q     <= '0;
            ovf_q    <= 1'b0;
        end else if (reject) begin
            z1_q  <= zstart_q;
            ovf_q <= 1'b1;
        end else if (accept) begin
            z1_q <= z1_q + PONE;
            if (commit) begin
                zstart_q <= z1_q + PONE;
                f1_q     <= f1_q + FONE;
            end
        end
    end

    assign mem_we   = accept;
    assign z1       = z1_q;
    assign f1       = f1_q;
    assign overflow = ovf_q;
endmodule

// File: rtl/frf_rd_ctrl.sv
module frf_rd_ctrl #(
    parameter int DEPTH = 512
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          rd_en,
    input  logic [frf_pkg::FCNT_W-1:0]    f1,
    input  logic                          word_eof,
    output logic [$clog2(DEPTH):0]        z2,
    output logic [frf_pkg::FCNT_W-1:0]    f2
);
    import frf_pkg::*;

    localparam int PW = $clog2(DEPTH) + 1;
    localparam logic [PW-1:0]     PONE = PW'(1);
    localparam logic [FCNT_W-1:0] FONE = FCNT_W'(1);

    logic [PW-1:0]     z2_q;
    logic [FCNT_W-1:0] f2_q;
    logic              pop;

    assign pop = rd_en && (f1 != f2_q);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            z2_q <= '0;
            f2_q <= '0;
        end else if (pop) begin
            z2_q <= z2_q + PONE;
            if (word_eof) begin
                f2_q <= f2_q + FONE;
            end
        end
    end

    assign z2 = z2_q;
    assign f2 = f2_q;
endmodule

// File: rtl/frf_rx_fifo.sv
module frf_rx_fifo #(
    parameter int DEPTH       = 512,
    parameter int FRAME_LIMIT = 15
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_valid,
    input  logic [7:0]                 wr_data,
    input  logic                       wr_eof,
    input  logic                       rd_en,
    output logic [7:0]                 rd_data,
    output logic                       rd_last,
    output logic [4:0]                 frames_stored,
    output logic [$clog2(DEPTH):0]     bytes_stored,
    output logic                       full,
    output logic                       overflow
);
    import frf_pkg::*;

    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;
    localparam logic [FCNT_W-1:0] FLIM = FCNT_W'(FRAME_LIMIT);
    localparam logic [PW-1:0]     BCAP = PW'(DEPTH);

    logic [PW-1:0]     z1, z2;
    logic [FCNT_W-1:0] f1, f2, fcount;
    logic [PW-1:0]     bcount;
    logic              mem_we;
    fifo_word_t        wword, rword;

    assign wword.eof  = wr_eof;
    assign wword.data = wr_data;

    frf_wr_ctrl #(.DEPTH(DEPTH)) u_wr (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_valid (wr_valid),
        .wr_eof   (wr_eof),
        .full     (full),
        .mem_we   (mem_we),
        .z1       (z1),
        .f1       (f1),
        .overflow (overflow)
    );

    frf_rd_ctrl #(.DEPTH(DEPTH)) u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_en    (rd_en),
        .f1       (f1),
        .word_eof (rword.eof),
        .z2       (z2),
        .f2       (f2)
    );

    frf_store #(.DEPTH(DEPTH)) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .waddr (z1[AW-1:0]),
        .wword (wword),
        .raddr (z2[AW-1:0]),
        .rword (rword)
    );

    assign fcount        = f1 - f2;
    assign bcount        = z1 - z2;
    assign full          = (fcount >= FLIM) || (bcount == BCAP);
    assign frames_stored = fcount;
    assign bytes_stored  = bcount;
    assign rd_data       = rword.data;
    assign rd_last       = (fcount != '0) && rword.eof;
endmodule

// File: rtl/frf_rx_fifo_chk.sv
module frf_rx_fifo_chk #(
    parameter int DEPTH       = 512,
    parameter int FRAME_LIMIT = 15
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   wr_valid,
    input logic                   wr_eof,
    input logic                   rd_en,
    input logic [4:0]             frames_stored,
    input logic [$clog2(DEPTH):0] bytes_stored,
    input logic                   full,
    input logic                   overflow
);
    localparam int PW = $clog2(DEPTH) + 1;

    // R7
    frame_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frames_stored <= 5'(FRAME_LIMIT));

    // R8
    byte_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bytes_stored <= PW'(DEPTH));

    // R9
    no_growth_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full |=> bytes_stored <= $past(bytes_stored));

    // R9
    overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);

    // R4
    commit_on_eof_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_valid && wr_eof) |=> frames_stored <= $past(frames_stored));

    // R5
    idle_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_valid && rd_en && frames_stored == 5'd0) |=> bytes_stored == $past(bytes_stored));
endmodule

bind frf_rx_fifo frf_rx_fifo_chk #(.DEPTH(DEPTH), .FRAME_LIMIT(FRAME_LIMIT)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_valid      (wr_valid),
    .wr_eof        (wr_eof),
    .rd_en         (rd_en),
    .frames_stored (frames_stored),
    .bytes_stored  (bytes_stored),
    .full          (full),
    .overflow      (overflow)
);

// File: tb/tb_frf_rx_fifo.sv
module tb_frf_rx_fifo;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 512;
    localparam int LIM        = 15;
    localparam int PW         = $clog2(DEPTH) + 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_valid = 1'b0;
    logic [7:0]    wr_data = 8'h00;
    logic          wr_eof = 1'b0;
    logic          rd_en = 1'b0;
    logic [7:0]    rd_data;
    logic          rd_last;
    logic [4:0]    frames_stored;
    logic [PW-1:0] bytes_stored;
    logic          full;
    logic          overflow;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // scoreboard: {last, data} of committed frames; pend holds the open frame
    logic [8:0] sb[$];
    logic [8:0] pend[$];
    int  m_bytes = 0;
    int  m_frames = 0;
    bit  m_drop = 1'b0;
    bit  m_ovf = 1'b0;

    frf_rx_fifo #(.DEPTH(DEPTH), .FRAME_LIMIT(LIM)) dut (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
        .wr_eof(wr_eof), .rd_en(rd_en), .rd_data(rd_data), .rd_last(rd_last),
        .frames_stored(frames_stored), .bytes_stored(bytes_stored),
        .full(full), .overflow(overflow)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic check_state(input string req);
        bit efull;
        efull = (m_frames >= LIM) || (m_bytes == DEPTH);
        chk(int'(frames_stored) == m_frames, req, "frames_stored", int'(frames_stored), m_frames);
        chk(int'(bytes_stored) == m_bytes, req, "bytes_stored", int'(bytes_stored), m_bytes);
        chk(full == efull, req, "full", int'(full), int'(efull));
        chk(overflow == m_ovf, req, "overflow", int'(overflow), int'(m_ovf));
    endtask

    // driver: one byte offer, model decides acceptance from the requirements
    task automatic put(input logic [7:0] d, input bit eof);
        bit efull;
        efull = (m_frames >= LIM) || (m_bytes == DEPTH);
        if (m_drop) begin
            if (eof) m_drop = 1'b0;
        end else if (efull) begin
            m_ovf   = 1'b1;
            m_bytes = m_bytes - pend.size();
            pend.delete();
            m_drop  = !eof;
        end else begin
            pend.push_back({eof, d});
            m_bytes++;
            if (eof) begin
                while (pend.size() > 0) sb.push_back(pend.pop_front());
                m_frames++;
            end
        end
        wr_valid = 1'b1; wr_data = d; wr_eof = eof;
        @(posedge clk); #1;
        wr_valid = 1'b0; wr_eof = 1'b0;
    endtask

    task automatic put_frame(input int len, input int seed);
        for (int i = 0; i < len; i++) put(8'((seed + i * 7) & 8'hff), i == len - 1);
    endtask

    task automatic get();
        if (m_frames > 0) begin
            m_bytes--;
            if (sb[0][8]) m_frames--;
        end
        rd_en = 1'b1;
        @(posedge clk); #1;
        rd_en = 1'b0;
    endtask

    task automatic drain();
        while (m_frames > 0) get();
    endtask

    // monitor: compares the byte about to be taken against the scoreboard (R2, R4)
    always @(negedge clk) begin
        if (rst_n && rd_en && frames_stored != 5'd0) begin
            if (sb.size() == 0) begin
                chk(1'b0, "R2", "read with empty scoreboard", int'(rd_data), -1);
            end else begin
                logic [8:0] e;
                e = sb.pop_front();
                chk(rd_data == e[7:0], "R2", "rd_data", int'(rd_data), int'(e[7:0]));
                chk(rd_last == e[8], "R4", "rd_last", int'(rd_last), int'(e[8]));
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check_state("R1");
        chk(rd_last == 1'b0, "R1", "rd_last", int'(rd_last), 0);

        // R3: idle data/eof toggling has no effect
        for (int i = 0; i < 4; i++) begin
            wr_data = 8'(i * 31); wr_eof = i[0];
            @(posedge clk); #1;
        end
        wr_eof = 1'b0;
        check_state("R3");

        // R5: partial frame not readable
        for (int i = 0; i < 3; i++) put(8'(8'h40 + i), 1'b0);
        get(); get();
        check_state("R5");
        put(8'h4f, 1'b1);
        // R2, R4: frame of 4 committed
        check_state("R4");
        drain();
        // R6
        check_state("R6");

        // several frames of different lengths incl. one-byte
        put_frame(1, 3); put_frame(6, 100); put_frame(2, 200);
        check_state("R2");
        get(); get();
        check_state("R6");
        drain();
        check_state("R6");

        // R7: one-byte frames up to the frame limit
        for (int i = 0; i < LIM; i++) put_frame(1, i);
        check_state("R7");
        // R9: offer while full by frames
        put(8'hee, 1'b0);
        check_state("R9");
        put(8'hef, 1'b1);
        check_state("R9");
        get();
        // R10: room again, new frame stored
        put_frame(3, 50);
        check_state("R10");
        drain();
        check_state("R9");

        // R8: one frame filling the whole byte store
        put_frame(DEPTH, 9);
        check_state("R8");
        put(8'h11, 1'b1);
        check_state("R9");
        drain();

        // R8/R9: oversized frame, full mid-frame then rolled back
        for (int i = 0; i < DEPTH; i++) put(8'(i), 1'b0);
        check_state("R8");
        put(8'h22, 1'b0);
        check_state("R9");
        for (int i = 0; i < 20; i++) put(8'(i), 1'b0);
        put(8'h33, 1'b1);
        check_state("R9");
        put_frame(5, 77);
        check_state("R10");
        drain();
        check_state("R6");
        chk(sb.size() == 0, "R2", "scoreboard leftover", sb.size(), 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule